// File: doc/BRIEF.md
# Buffered PPG Cycle Counter

This block is a programmable pulse generator timer. A down counter produces a repeating period whose length, in count-enable ticks, is set by a cycle value. A PWM output is high for the part of each period set by a duty value. The counter can work as one 16-bit counter or as an 8-bit counter that looks only at the low byte. Software writes the cycle and the duty one byte at a time through a write port with byte enables. The bytes go into shadow buffers. The counter copies the buffers into its active registers only when it starts and at each period boundary. A period that is already running therefore always finishes with the values it started with.

The counter runs while `run` is high and advances on each clock where `cntEn` is high. It counts down from the cycle value to 1. On the tick that finds the count at 1, it reloads from the buffers and raises `periodEnd` for one clock. A cycle value of 0 or 1 has no defined period. Such a value raises `cfgError`, and the block then holds its outputs quiet.

Top module: `ppg_cycle_timer`

## Requirements
- R1: After reset, `periodEnd`, `pwmOut` and `cfgError` are low, and every cycle buffer bit is 1. Started with no writes, a period is 255 ticks in 8-bit mode and 65535 ticks in 16-bit mode.
- R2: In 16-bit mode (`mode16`=1) the cycle value is {high byte, low byte}. Write lane 1 (`wrByteEn[1]`, `wrData[15:8]`) carries the high byte and lane 0 (`wrByteEn[0]`, `wrData[7:0]`) carries the low byte. The two bytes may be written in one write or in two separate writes.
- R3: In 8-bit mode (`mode16`=0) only the low byte sets the cycle and the duty, and the high byte has no effect.
- R4: A write to the cycle (`wrSel`=0) or duty (`wrSel`=1) buffers while the timer runs does not change the current period. It takes effect from the next period.
- R5: A write of only the high byte makes the next reload combine the new high byte with the low byte written earlier.
- R6: On start (`run` rising), the active registers are loaded straight from the buffers. The first `periodEnd` appears N clocks after the start edge when `cntEn` is held high, where N is the cycle value.
- R7: A period takes exactly N count-enable ticks. The counter does not move on clocks with `cntEn` low. `periodEnd` is high for a single clock at each boundary.
- R8: Over each period of N ticks, `pwmOut` is high for N−D+1 ticks when 1≤D≤N, for N ticks when D=0, and for 0 ticks when D>N, where D is the duty value. It is high at the start of the period.
- R9: An active cycle value of 0 or 1 raises `cfgError` from the clock after it is loaded. While `cfgError` is high, `pwmOut` and `periodEnd` stay low.
- R10: While stopped (`run` low on the previous clock edge), `pwmOut`, `periodEnd` and `cfgError` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | High to run the timer, low to stop it |
| cntEn | input | 1 | Count-enable tick |
| mode16 | input | 1 | 1: 16-bit counter, 0: 8-bit counter on the low byte |
| wrEn | input | 1 | Buffer write strobe |
| wrSel | input | 1 | 0: cycle buffers, 1: duty buffers |
| wrByteEn | input | 2 | Byte lane enables, bit 1 high byte, bit 0 low byte |
| wrData | input | 16 | Write data, high byte on bits 15:8 |
| periodEnd | output | 1 | One-clock strobe at each period boundary |
| pwmOut | output | 1 | PWM output |
| cfgError | output | 1 | Active cycle value is 0 or 1 |

## Verification
A buffer write is visible one clock after it is driven, but it changes the outputs only at the next start or boundary. The bench therefore measures whole periods and makes no check in the clock right after a write. After the start edge, `periodEnd` goes high in the clock that follows the N-th tick, so the bench counts falling edges from the start, and from strobe to strobe, and compares the count with the cycle value. The PWM high time is counted over the N falling edges that begin with a strobe, because the count is already N when the strobe is seen. `cfgError` is sampled at the first falling edge after the start edge, when the loaded value first drives it.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  // Strobes from the control to the datapath, at most one of them high per clock
  typedef struct packed {
    logic start;  // begin running, load active registers from the buffers
    logic stop;   // leave running, clear the counter
    logic dec;    // count-enable tick in the middle of a period
    logic wrap;   // count-enable tick at the terminal count
  } ppgStrobe_t;

endpackage

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
  import ppg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       cntEn,
  input  logic       atTerminal,
  output logic       running,
  output ppgStrobe_t strb
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= run;
  end

  logic tickOk;
  assign tickOk = run & running & cntEn;

  always_comb begin
    strb.start = run & ~running;
    strb.stop  = ~run & running;
    strb.dec   = tickOk & ~atTerminal;
    strb.wrap  = tickOk & atTerminal;
  end

endmodule

// File: rtl/ppg_datapath.sv
module ppg_datapath
  import ppg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ppgStrobe_t       strb,
  input  logic             running,
  input  logic             mode16,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [1:0]       wrByteEn,
  input  logic [CNT_W-1:0] wrData,
  output logic             atTerminal,
  output logic             periodEnd,
  output logic             pwmOut,
  output logic             cfgError
);

  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] MIN_OK = CNT_W'(2);

  // Shadow buffers, lane 1 is the high byte
  logic [1:0][HALF_W-1:0] cycBuf;
  logic [1:0][HALF_W-1:0] dutyBuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycBuf  <= '1;
      dutyBuf <= '0;
    end else if (wrEn) begin
      for (int lane = 0; lane < 2; lane++) begin
        if (wrByteEn[lane]) begin
          if (wrSel) dutyBuf[lane] <= wrData[lane*HALF_W +: HALF_W];
          else       cycBuf[lane]  <= wrData[lane*HALF_W +: HALF_W];
        end
      end
    end
  end

  // Value the next reload picks up, narrowed in 8-bit mode
  logic [CNT_W-1:0] nextCycle;
  logic [CNT_W-1:0] nextDuty;

  always_comb begin
    if (mode16) begin
      nextCycle = cycBuf;
      nextDuty  = dutyBuf;
    end else begin
      nextCycle = {{HALF_W{1'b0}}, cycBuf[0]};
      nextDuty  = {{HALF_W{1'b0}}, dutyBuf[0]};
    end
  end

  logic [CNT_W-1:0] actCycle;
  logic [CNT_W-1:0] actDuty;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actCycle  <= '1;
      actDuty   <= '0;
      count     <= '0;
      periodEnd <= 1'b0;
    end else begin
      periodEnd <= strb.wrap & (nextCycle >= MIN_OK);
      if (strb.stop) begin
        count <= '0;
      end else if (strb.start || strb.wrap) begin
        actCycle <= nextCycle;
        actDuty  <= nextDuty;
        count    <= nextCycle;
      end else if (strb.dec) begin
        count <= count - CNT_W'(1);
      end
    end
  end

  logic badCycle;
  assign badCycle   = actCycle < MIN_OK;
  assign atTerminal = count <= CNT_W'(1);
  assign cfgError   = running & badCycle;
  assign pwmOut     = running & ~badCycle & (count >= actDuty);

endmodule

// File: rtl/ppg_cycle_timer.sv
module ppg_cycle_timer
  import ppg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cntEn,
  input  logic             mode16,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [1:0]       wrByteEn,
  input  logic [CNT_W-1:0] wrData,
  output logic             periodEnd,
  output logic             pwmOut,
  output logic             cfgError
);

  ppgStrobe_t strb;
  logic       running;
  logic       atTerminal;

  ppg_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .cntEn      (cntEn),
    .atTerminal (atTerminal),
    .running    (running),
    .strb       (strb)
  );

  ppg_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .running    (running),
    .mode16     (mode16),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrByteEn   (wrByteEn),
    .wrData     (wrData),
    .atTerminal (atTerminal),
    .periodEnd  (periodEnd),
    .pwmOut     (pwmOut),
    .cfgError   (cfgError)
  );

endmodule

// File: rtl/ppg_chk.sv
module ppg_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic cntEn,
  input logic periodEnd,
  input logic pwmOut,
  input logic cfgError
);

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periodEnd |=> !periodEnd);

  // R9
  error_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfgError |-> (!pwmOut && !periodEnd));

  // R10
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (!pwmOut && !periodEnd && !cfgError));

  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !cntEn) |=> ($stable(pwmOut) && !periodEnd));

endmodule

bind ppg_cycle_timer ppg_chk i_ppg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .cntEn     (cntEn),
  .periodEnd (periodEnd),
  .pwmOut    (pwmOut),
  .cfgError  (cfgError)
);

// File: tb/test_ppg_cycle_timer.sv
module test_ppg_cycle_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cntEn = 1'b1;
  logic        mode16 = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [1:0]  wrByteEn = 2'b00;
  logic [15:0] wrData = 16'h0000;
  logic        periodEnd, pwmOut, cfgError;

  int checks = 0;
  int failures = 0;
  bit halfRate = 1'b0;

  always #10 clk = ~clk;

  ppg_cycle_timer i_ppg_cycle_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .cntEn(cntEn), .mode16(mode16),
    .wrEn(wrEn), .wrSel(wrSel), .wrByteEn(wrByteEn), .wrData(wrData),
    .periodEnd(periodEnd), .pwmOut(pwmOut), .cfgError(cfgError)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expHigh(input int n, input int d);
    if (d == 0) return n;
    if (d > n) return 0;
    return n - d + 1;
  endfunction

  task automatic busWrite(input bit sel, input logic [1:0] be, input logic [15:0] data);
    wrEn = 1'b1; wrSel = sel; wrByteEn = be; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrByteEn = 2'b00;
  endtask

  task automatic startRun(output int first);
    int i = 0;
    run = 1'b1;
    do begin
      @(negedge clk);
      i++;
    end while (!periodEnd && i < 70000);
    first = i - 1;
  endtask

  task automatic stopRun();
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Starts at a strobe; returns the gap to the next strobe and the PWM high count
  task automatic runPeriod(input bit doWrite, input bit sel, input logic [1:0] be,
                           input logic [15:0] data, output int gap, output int highs);
    int g = 0;
    int h = pwmOut;
    if (halfRate) cntEn = 1'b0;
    if (doWrite) begin
      wrEn = 1'b1; wrSel = sel; wrByteEn = be; wrData = data;
    end
    do begin
      @(negedge clk);
      wrEn = 1'b0; wrByteEn = 2'b00;
      if (halfRate) cntEn = ~cntEn;
      g++;
      if (!periodEnd) h += pwmOut;
    end while (!periodEnd && g < 70000);
    gap = g;
    highs = h;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int f, g, h;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!periodEnd && !pwmOut && !cfgError, "R1 reset outputs", {periodEnd, pwmOut, cfgError}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pwmOut && !cfgError, "R10 stopped after reset", {pwmOut, cfgError}, 0);

    // R1 reset buffers, 8-bit then 16-bit
    mode16 = 1'b0;
    startRun(f);
    check(f == 255, "R1 8-bit reset period", f, 255);
    stopRun();
    check(!pwmOut && !periodEnd && !cfgError, "R10 stopped", {pwmOut, periodEnd, cfgError}, 0);
    mode16 = 1'b1;
    startRun(f);
    check(f == 65535, "R1 R2 16-bit reset period", f, 65535);
    stopRun();

    // R6 R7 R8 sweep in 8-bit mode
    mode16 = 1'b0;
    for (int n = 2; n <= 9; n++) begin
      for (int d = 0; d <= 10; d++) begin
        busWrite(1'b0, 2'b01, 16'(n));
        busWrite(1'b1, 2'b01, 16'(d));
        startRun(f);
        check(f == n, "R6 first period", f, n);
        runPeriod(1'b0, 1'b0, 2'b00, 16'h0, g, h);
        check(g == n, "R7 period length", g, n);
        check(h == expHigh(n, d), "R8 pwm high ticks", h, expHigh(n, d));
        stopRun();
      end
    end

    // R2 separate high then low writes
    mode16 = 1'b1;
    busWrite(1'b1, 2'b11, 16'h0000);
    busWrite(1'b0, 2'b10, 16'h0200);
    busWrite(1'b0, 2'b01, 16'h0010);
    startRun(f);
    check(f == 528, "R2 split byte writes", f, 528);
    stopRun();

    // R2 one write, then R4 R5 high-only write mid-period
    busWrite(1'b0, 2'b11, 16'h0105);
    startRun(f);
    runPeriod(1'b0, 1'b0, 2'b00, 16'h0, g, h);
    check(g == 261, "R2 combined write", g, 261);
    runPeriod(1'b1, 1'b0, 2'b10, 16'h0000, g, h);
    check(g == 261, "R4 current period kept", g, 261);
    runPeriod(1'b0, 1'b0, 2'b00, 16'h0, g, h);
    check(g == 5, "R5 high-only reload keeps low", g, 5);
    stopRun();

    // R3 high byte ignored in 8-bit mode
    mode16 = 1'b0;
    busWrite(1'b0, 2'b11, 16'h1207);
    busWrite(1'b1, 2'b11, 16'h1203);
    startRun(f);
    check(f == 7, "R3 8-bit first period", f, 7);
    runPeriod(1'b0, 1'b0, 2'b00, 16'h0, g, h);
    check(g == 7, "R3 8-bit period", g, 7);
    check(h == 5, "R3 8-bit duty low byte", h, 5);
    stopRun();

    // R4 cycle and duty changes mid-period
    busWrite(1'b0, 2'b01, 16'd5);
    busWrite(1'b1, 2'b01, 16'd2);
    startRun(f);
    runPeriod(1'b1, 1'b0, 2'b01, 16'd9, g, h);
    check(g == 5, "R4 cycle change deferred", g, 5);
    check(h == 4, "R4 pwm old period", h, 4);
    runPeriod(1'b1, 1'b1, 2'b01, 16'd4, g, h);
    check(g == 9, "R4 new cycle used", g, 9);
    check(h == 8, "R4 duty change deferred", h, 8);
    runPeriod(1'b0, 1'b0, 2'b00, 16'h0, g, h);
    check(h == 6, "R4 new duty used", h, 6);

    // R7 half-rate ticks and stall
    halfRate = 1'b1;
    runPeriod(1'b0, 1'b0, 2'b00, 16'h0, g, h);
    halfRate = 1'b0;
    cntEn = 1'b1;
    check(g == 18, "R7 half-rate period", g, 18);
    cntEn = 1'b0;
    f = 0;
    repeat (30) begin
      @(negedge clk);
      f += periodEnd;
    end
    check(f == 0, "R7 no strobe without ticks", f, 0);
    cntEn = 1'b1;
    stopRun();

    // R9 illegal cycle values
    busWrite(1'b0, 2'b01, 16'd1);
    run = 1'b1;
    @(negedge clk);
    check(cfgError, "R9 cycle 1 flagged", cfgError, 1);
    f = 0;
    repeat (20) begin
      @(negedge clk);
      f += periodEnd + pwmOut;
    end
    check(f == 0, "R9 outputs quiet", f, 0);
    stopRun();
    check(!cfgError, "R10 error cleared when stopped", cfgError, 0);
    mode16 = 1'b1;
    busWrite(1'b0, 2'b11, 16'h0000);
    run = 1'b1;
    @(negedge clk);
    check(cfgError, "R9 cycle 0 flagged", cfgError, 1);
    stopRun();
    busWrite(1'b0, 2'b10, 16'h0100);
    run = 1'b1;
    @(negedge clk);
    check(!cfgError, "R9 cycle 256 legal", cfgError, 0);
    stopRun();
    startRun(f);
    check(f == 256, "R2 R9 cycle 256 period", f, 256);
    stopRun();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule